// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit input address into a 40-bit physical address by walking a two-level table held in external memory. The top ten address bits select an entry in a 1024-entry directory. A valid directory entry points at a 1024-entry page table, and the next ten bits select a leaf entry in that page table. A valid leaf entry supplies the frame of a 4 KiB page. The low twelve bits pass through unchanged as the byte offset. Each 32-bit leaf carries physical bits 39:32 in its bits 11:4, which is how a 32-bit descriptor can describe a 40-bit address.

A single cached translation means that repeated accesses to the same page are answered without touching memory. A one-cycle invalidate pulse drops the cached entry. The block takes one request at a time and returns either a physical address or a fault code. It reads table words through a simple port: a one-cycle read pulse with a word address, then a response strobe with the data.

Top module: `ptw_top`

## Requirements
- R1: On a miss, the directory word is read at `{dir_base, 10'b0} + 4*vaddr[31:22]`. When that word is valid, the leaf word is read next, at `(directory word & 0xFFFFFFC0) + 4*vaddr[21:12]`. No translation issues more than these two reads.
- R2: A directory word whose bit 0 is 0 ends the walk after that single read with `rsp_fault`=1 and `rsp_code`=1.
- R3: A leaf word whose bit 0 is 0 ends the walk with `rsp_fault`=1 and `rsp_code`=2.
- R4: A write request to a page whose leaf bit 2 is 0 returns `rsp_fault`=1 and `rsp_code`=3. Read requests to that page and writes to pages with bit 2 set return code 0.
- R5: On success (`rsp_code`=0), `rsp_paddr` = {leaf[11:4], leaf[31:12], vaddr[11:0]}.
- R6: A request whose vaddr[31:12] matches the cached translation is answered in the cycle after acceptance, with no memory read. A write to a read-only page found in the cache gives code 3.
- R7: A `flush` pulse invalidates the cached translation at once, so the next request performs a full walk.
- R8: A walk that is in progress when `flush` pulses still returns its correct result, but the result is not cached.
- R9: `req_ready` goes low from the cycle after acceptance until the response has been given. `rsp_valid` is a single-cycle pulse.
- R10: During and after reset, `req_ready` is 1, and `rsp_valid` and `mem_req` are 0.
- R11: A walk that ends in a directory or leaf fault leaves the cached translation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | High when a request can be accepted |
| req_vaddr | input | 32 | Input address |
| req_write | input | 1 | Request is a write access |
| dir_base | input | 22 | Directory address bits 31:10 |
| flush | input | 1 | Invalidate pulse for the cached translation |
| mem_req | output | 1 | One-cycle table read pulse |
| mem_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Table word read |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 1 | Result is a fault |
| rsp_code | output | 2 | 0 ok, 1 directory invalid, 2 leaf invalid, 3 write denied |
| rsp_paddr | output | 40 | Translated address |

## Verification
The bench builds the block with its default geometry (32-bit input, ten index bits per level, 40-bit output) and with the cached-entry variant selected. This makes the hit path, the flush paths and the fault-does-not-disturb case reachable. The behavioural memory answers three cycles after each read pulse, so a walk is long enough for a flush to land inside it. Directory and page-table entries sit at index 0x3FF and at interior indices. The directory word is given junk in bits 5:1 to confirm that the table base is masked.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam int ENT_VALID_BIT = 0;
   localparam int LEAF_WR_BIT   = 2;
   localparam int LEAF_HI_LSB   = 4;
   localparam int PT_ALIGN_LSB  = 6;
   localparam int DIR_ALIGN_LSB = 10;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_DIR  = 2'd1,
      FLT_LEAF = 2'd2,
      FLT_PERM = 2'd3
   } flt_e;

   typedef enum logic [2:0] {
      S_IDLE, S_DREQ, S_DWAIT, S_LREQ, S_LWAIT, S_RESP
   } walk_st_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int VA_W  = 32,
   parameter int IDX_W = 10,
   parameter int OFF_W = 12,
   parameter int AW    = 32,
   parameter int DB_W  = 22
) (
   input  logic [DB_W-1:0]                        dir_base,
   input  logic [VA_W-1:0]                        va,
   input  logic [AW-ptw_pkg::PT_ALIGN_LSB-1:0]    pt_base,
   output logic [AW-1:0]                          dir_addr,
   output logic [AW-1:0]                          leaf_addr
);
   localparam int DLOW = AW - DB_W;
   localparam int PLOW = ptw_pkg::PT_ALIGN_LSB;

   logic [AW-1:0] dir_off, leaf_off;

   always_comb begin
      dir_off   = AW'({va[VA_W-1 -: IDX_W], 2'b00});
      leaf_off  = AW'({va[OFF_W+IDX_W-1:OFF_W], 2'b00});
      dir_addr  = {dir_base, {DLOW{1'b0}}} + dir_off;
      leaf_addr = {pt_base, {PLOW{1'b0}}} + leaf_off;
   end
endmodule

// File: rtl/ptw_xlat_cache.sv
module ptw_xlat_cache #(
   parameter int TAG_W   = 20,
   parameter int FRAME_W = 28
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic [TAG_W-1:0]   lk_tag,
   output logic               hit,
   output logic [FRAME_W-1:0] hit_frame,
   output logic               hit_wr,
   input  logic               fill_en,
   input  logic [TAG_W-1:0]   fill_tag,
   input  logic [FRAME_W-1:0] fill_frame,
   input  logic               fill_wr
);
   logic               vld_q;
   logic [TAG_W-1:0]   tag_q;
   logic [FRAME_W-1:0] frame_q;
   logic               wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         tag_q   <= '0;
         frame_q <= '0;
         wr_q    <= 1'b0;
      end else if (flush) begin
         vld_q <= 1'b0;
      end else if (fill_en) begin
         vld_q   <= 1'b1;
         tag_q   <= fill_tag;
         frame_q <= fill_frame;
         wr_q    <= fill_wr;
      end
   end

   assign hit       = vld_q && (tag_q == lk_tag) && !flush;
   assign hit_frame = frame_q;
   assign hit_wr    = wr_q;
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
   import ptw_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int OFF_W   = 12,
   parameter int AW      = 32,
   parameter int DB_W    = 22,
   parameter int PA_W    = 40,
   parameter int TAG_W   = 20,
   parameter int FRAME_W = 28,
   parameter int HI_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic [VA_W-1:0]             req_vaddr,
   input  logic                        req_write,
   input  logic [DB_W-1:0]             dir_base,
   input  logic                        flush,
   input  logic                        c_hit,
   input  logic [FRAME_W-1:0]          c_frame,
   input  logic                        c_wr,
   output logic [TAG_W-1:0]            lk_tag,
   output logic                        fill_en,
   output logic [TAG_W-1:0]            fill_tag,
   output logic [FRAME_W-1:0]          fill_frame,
   output logic                        fill_wr,
   output logic [VA_W-1:0]             va_q,
   output logic [DB_W-1:0]             base_q,
   output logic [AW-PT_ALIGN_LSB-1:0]  pt_q,
   input  logic [AW-1:0]               dir_addr,
   input  logic [AW-1:0]               leaf_addr,
   output logic                        mem_req,
   output logic [AW-1:0]               mem_addr,
   input  logic                        mem_rsp_valid,
   input  logic [AW-1:0]               mem_rsp_data,
   output logic                        rsp_valid,
   output logic [1:0]                  rsp_code,
   output logic [PA_W-1:0]             rsp_paddr
);
   walk_st_e st;
   logic     wr_q, poison_q;
   flt_e     code_q;
   logic [FRAME_W-1:0] leaf_frame;
   logic               leaf_ok, leaf_wr;

   assign leaf_frame = {mem_rsp_data[LEAF_HI_LSB +: HI_W], mem_rsp_data[AW-1:OFF_W]};
   assign leaf_ok    = mem_rsp_data[ENT_VALID_BIT];
   assign leaf_wr    = mem_rsp_data[LEAF_WR_BIT];

   assign req_ready = (st == S_IDLE);
   assign lk_tag    = req_vaddr[VA_W-1:OFF_W];
   assign mem_req   = (st == S_DREQ) || (st == S_LREQ);
   assign mem_addr  = (st == S_LREQ) ? leaf_addr : dir_addr;
   assign rsp_code  = code_q;

   assign fill_en    = (st == S_LWAIT) && mem_rsp_valid && leaf_ok && !poison_q && !flush;
   assign fill_tag   = va_q[VA_W-1:OFF_W];
   assign fill_frame = leaf_frame;
   assign fill_wr    = leaf_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         va_q      <= '0;
         wr_q      <= 1'b0;
         base_q    <= '0;
         pt_q      <= '0;
         poison_q  <= 1'b0;
         rsp_valid <= 1'b0;
         code_q    <= FLT_NONE;
         rsp_paddr <= '0;
      end else begin
         if (flush && st != S_IDLE) poison_q <= 1'b1;
         unique case (st)
            S_IDLE: if (req_valid) begin
               va_q     <= req_vaddr;
               wr_q     <= req_write;
               base_q   <= dir_base;
               poison_q <= 1'b0;
               if (c_hit) begin
                  rsp_valid <= 1'b1;
                  rsp_paddr <= {c_frame, req_vaddr[OFF_W-1:0]};
                  code_q    <= (req_write && !c_wr) ? FLT_PERM : FLT_NONE;
                  st        <= S_RESP;
               end else begin
                  st <= S_DREQ;
               end
            end
            S_DREQ: st <= S_DWAIT;
            S_DWAIT: if (mem_rsp_valid) begin
               if (!mem_rsp_data[ENT_VALID_BIT]) begin
                  code_q    <= FLT_DIR;
                  rsp_valid <= 1'b1;
                  st        <= S_RESP;
               end else begin
                  pt_q <= mem_rsp_data[AW-1:PT_ALIGN_LSB];
                  st   <= S_LREQ;
               end
            end
            S_LREQ: st <= S_LWAIT;
            S_LWAIT: if (mem_rsp_valid) begin
               rsp_valid <= 1'b1;
               st        <= S_RESP;
               if (!leaf_ok) begin
                  code_q <= FLT_LEAF;
               end else begin
                  rsp_paddr <= {leaf_frame, va_q[OFF_W-1:0]};
                  code_q    <= (wr_q && !leaf_wr) ? FLT_PERM : FLT_NONE;
               end
            end
            S_RESP: begin
               rsp_valid <= 1'b0;
               st        <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
   import ptw_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int IDX_W     = 10,
   parameter int OFF_W     = 12,
   parameter int AW        = 32,
   parameter int PA_W      = 40,
   parameter int DB_W      = AW - DIR_ALIGN_LSB,
   parameter bit USE_CACHE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic             req_write,
   input  logic [DB_W-1:0]  dir_base,
   input  logic             flush,
   output logic             mem_req,
   output logic [AW-1:0]    mem_addr,
   input  logic             mem_rsp_valid,
   input  logic [AW-1:0]    mem_rsp_data,
   output logic             rsp_valid,
   output logic             rsp_fault,
   output logic [1:0]       rsp_code,
   output logic [PA_W-1:0]  rsp_paddr
);
   localparam int TAG_W   = VA_W - OFF_W;
   localparam int FRAME_W = PA_W - OFF_W;
   localparam int HI_W    = PA_W - AW;

   initial begin
      assert (VA_W == 2*IDX_W + OFF_W) else $error("address split does not cover input width");
      assert (LEAF_HI_LSB + HI_W <= OFF_W) else $error("upper frame bits do not fit in leaf");
      assert (DB_W == AW - DIR_ALIGN_LSB) else $error("directory base width mismatch");
   end

   logic [TAG_W-1:0]   lk_tag, fill_tag;
   logic [FRAME_W-1:0] c_frame, fill_frame;
   logic               c_hit, c_wr, fill_en, fill_wr;
   logic [VA_W-1:0]    va_q;
   logic [DB_W-1:0]    base_q;
   logic [AW-PT_ALIGN_LSB-1:0] pt_q;
   logic [AW-1:0]      dir_addr, leaf_addr;

   ptw_addr_gen #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .AW(AW), .DB_W(DB_W)) u_agen (
      .dir_base(base_q), .va(va_q), .pt_base(pt_q),
      .dir_addr(dir_addr), .leaf_addr(leaf_addr)
   );

   generate
      if (USE_CACHE) begin : g_cache
         ptw_xlat_cache #(.TAG_W(TAG_W), .FRAME_W(FRAME_W)) u_cache (
            .clk(clk), .rst_n(rst_n), .flush(flush), .lk_tag(lk_tag),
            .hit(c_hit), .hit_frame(c_frame), .hit_wr(c_wr),
            .fill_en(fill_en), .fill_tag(fill_tag), .fill_frame(fill_frame), .fill_wr(fill_wr)
         );
      end else begin : g_nocache
         assign c_hit   = 1'b0;
         assign c_frame = '0;
         assign c_wr    = 1'b0;
      end
   endgenerate

   ptw_walk_fsm #(
      .VA_W(VA_W), .OFF_W(OFF_W), .AW(AW), .DB_W(DB_W), .PA_W(PA_W),
      .TAG_W(TAG_W), .FRAME_W(FRAME_W), .HI_W(HI_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_write(req_write), .dir_base(dir_base), .flush(flush),
      .c_hit(c_hit), .c_frame(c_frame), .c_wr(c_wr), .lk_tag(lk_tag),
      .fill_en(fill_en), .fill_tag(fill_tag), .fill_frame(fill_frame), .fill_wr(fill_wr),
      .va_q(va_q), .base_q(base_q), .pt_q(pt_q),
      .dir_addr(dir_addr), .leaf_addr(leaf_addr),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr)
   );

   assign rsp_fault = rsp_valid && (rsp_code != FLT_NONE);
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
   parameter int OFF_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [OFF_W-1:0] req_off,
   input logic             flush,
   input logic             mem_req,
   input logic [1:0]       mem_lsb,
   input logic             rsp_valid,
   input logic [OFF_W-1:0] rsp_off,
   input logic [1:0]       rsp_code
);
   logic [1:0]       rd_cnt;
   logic [OFF_W-1:0] off_q;
   logic             pend_q, arm_q;
   logic             acc;

   assign acc = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_cnt <= '0;
         off_q  <= '0;
         pend_q <= 1'b0;
         arm_q  <= 1'b0;
      end else if (acc) begin
         rd_cnt <= '0;
         off_q  <= req_off;
         arm_q  <= pend_q || flush;
         pend_q <= 1'b0;
      end else begin
         if (mem_req && rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
         if (flush) pend_q <= 1'b1;
      end
   end

   assert_word_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_lsb == 2'b00);
   assert_two_reads_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rd_cnt <= 2'd2);
   assert_dir_fault_one_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == 2'd1) |-> rd_cnt == 2'd1);
   assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == 2'd0) |-> rsp_off == off_q);
   assert_flush_forces_walk_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && arm_q) |-> rd_cnt != 2'd0);
   assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !req_ready);
   assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   assert_read_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
endmodule

bind ptw_top ptw_chk #(.OFF_W(OFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_off(req_vaddr[OFF_W-1:0]), .flush(flush), .mem_req(mem_req),
   .mem_lsb(mem_addr[1:0]), .rsp_valid(rsp_valid),
   .rsp_off(rsp_paddr[OFF_W-1:0]), .rsp_code(rsp_code)
);

// File: tb/tb_ptw_top.sv
`timescale 1ns/1ps
module tb_ptw_top;
   localparam int LAT = 3;
   localparam logic [21:0] DBASE = 22'h00100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, flush = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_ready, mem_req, rsp_valid, rsp_fault;
   logic [31:0] mem_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic [1:0]  rsp_code;
   logic [39:0] rsp_paddr;

   always #4 clk = ~clk;

   ptw_top #(.USE_CACHE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_write(req_write), .dir_base(DBASE), .flush(flush),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
      .rsp_code(rsp_code), .rsp_paddr(rsp_paddr)
   );

   int n_vec = 0, n_bad = 0, n_done = 0, cyc = 0, acc_cyc = 0, nrd = 0;
   logic [31:0] rd_q[$];
   logic [31:0] mem [bit [31:0]];

   always @(posedge clk) cyc++;

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   // behavioural table memory: answers LAT cycles after a read pulse
   int          wcnt = 0;
   logic [31:0] paddr_q;
   always @(negedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (rst_n && mem_req) begin
         paddr_q = mem_addr;
         wcnt    = LAT;
         nrd++;
         rd_q.push_back(mem_addr);
      end else if (wcnt > 0) begin
         wcnt--;
         if (wcnt == 0) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= rd(paddr_q);
         end
      end
   end

   typedef struct {
      logic [39:0] pa;
      logic [1:0]  code;
      int          reads;
      logic [31:0] a0, a1;
      bit          hit;
      string       nm;
   } exp_t;
   exp_t sb[$];

   // requirement-level model of the single cached translation
   bit          m_vld = 0, m_wr = 0;
   logic [19:0] m_tag = '0;
   logic [27:0] m_frame = '0;

   task automatic fail(input string nm, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", nm, what, act, exp);
   endtask

   // monitor: pops expected results and compares
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            n_vec++;
            fail("R9", "response without request", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (rsp_code !== e.code || rsp_fault !== (e.code != 2'd0))
               fail(e.nm, "code", {rsp_fault, rsp_code}, {(e.code != 2'd0), e.code});
            if (e.code == 2'd0) begin
               n_vec++;
               if (rsp_paddr !== e.pa) fail(e.nm, "paddr", rsp_paddr, e.pa);
            end
            n_vec++;
            if (nrd != e.reads) fail(e.nm, "read count", nrd, e.reads);
            if (e.reads >= 1 && rd_q.size() >= 1) begin
               n_vec++;
               if (rd_q[0] !== e.a0) fail(e.nm, "directory read address", rd_q[0], e.a0);
            end
            if (e.reads == 2 && rd_q.size() >= 2) begin
               n_vec++;
               if (rd_q[1] !== e.a1) fail(e.nm, "leaf read address", rd_q[1], e.a1);
            end
            if (e.hit) begin
               n_vec++;
               if (cyc - acc_cyc != 0) fail(e.nm, "hit latency", cyc - acc_cyc, 0);
            end
            n_vec++;
            if (req_ready !== 1'b0) fail("R9", "ready during response", req_ready, 0);
         end
         n_done++;
      end
   end

   // driver: computes expectation, pushes it, then applies the request
   task automatic xlate(input logic [31:0] va, input bit wr, input bit fmid, input string nm);
      exp_t e;
      int   idx;
      logic [31:0] d, l;
      e.nm = nm; e.pa = '0; e.a0 = '0; e.a1 = '0; e.hit = 0;
      if (m_vld && m_tag == va[31:12]) begin
         e.hit = 1; e.reads = 0;
         e.pa = {m_frame, va[11:0]};
         e.code = (wr && !m_wr) ? 2'd3 : 2'd0;
      end else begin
         e.a0 = {DBASE, 10'b0} + {20'b0, va[31:22], 2'b00};
         d = rd(e.a0);
         e.reads = 1;
         if (!d[0]) e.code = 2'd1;
         else begin
            e.a1 = {d[31:6], 6'b0} + {20'b0, va[21:12], 2'b00};
            l = rd(e.a1);
            e.reads = 2;
            if (!l[0]) e.code = 2'd2;
            else begin
               e.pa = {l[11:4], l[31:12], va[11:0]};
               e.code = (wr && !l[2]) ? 2'd3 : 2'd0;
               if (fmid) m_vld = 0;
               else begin m_vld = 1; m_tag = va[31:12]; m_frame = {l[11:4], l[31:12]}; m_wr = l[2]; end
            end
         end
         if (fmid && !l[0]) m_vld = 0;
      end
      sb.push_back(e);
      idx = n_done + 1;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_write = wr;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      acc_cyc = cyc; nrd = 0; rd_q.delete();
      if (fmid) begin
         repeat (2) @(negedge clk);
         flush = 1'b1;
         @(negedge clk);
         flush = 1'b0;
      end
      wait (n_done >= idx);
   endtask

   task automatic do_flush();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      m_vld = 0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      // directory at 0x0004_0000
      mem[32'h0004_0010] = 32'h0010_007F;   // idx 4 -> table 0x100040, junk in bits 5:1
      mem[32'h0004_0FFC] = 32'h0020_0001;   // idx 0x3FF -> table 0x200000
      mem[32'h0010_0910] = 32'hABCD_E5A5;   // idx 0x234: writable, hi 0x5A
      mem[32'h0010_0914] = 32'h1234_50F1;   // idx 0x235: read-only, hi 0x0F
      mem[32'h0010_0C40] = 32'hFFFF_FFFE;   // idx 0x300: invalid leaf
      mem[32'h0020_0FFC] = 32'hFEDC_BFF5;   // idx 0x3FF: writable, hi 0xFF

      repeat (3) @(negedge clk);
      n_vec++;
      if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || mem_req !== 1'b0)
         fail("R10", "reset outputs", {req_ready, rsp_valid, mem_req}, 3'b100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      xlate(32'h0123_4567, 0, 0, "R1 R5 walk read");
      xlate(32'h0123_4ABC, 0, 0, "R6 hit read");
      xlate(32'h0123_4001, 1, 0, "R6 R4 hit write to writable page");
      xlate(32'h0123_5010, 1, 0, "R4 write to read-only page");
      xlate(32'h0123_5020, 1, 0, "R6 R4 hit write to read-only page");
      xlate(32'h0123_5030, 0, 0, "R4 read of read-only page");
      xlate(32'h0140_0000, 0, 0, "R2 directory fault");
      xlate(32'h0123_5040, 0, 0, "R11 hit kept after directory fault");
      xlate(32'h0130_0FFF, 0, 0, "R3 leaf fault");
      xlate(32'h0123_5050, 0, 0, "R11 hit kept after leaf fault");
      do_flush();
      xlate(32'h0123_5060, 0, 0, "R7 walk after flush");
      xlate(32'hFFFF_FFFF, 1, 0, "R1 R5 last indices");
      xlate(32'h0123_4100, 0, 1, "R8 flush during walk");
      xlate(32'h0123_4200, 0, 0, "R8 walk repeated, not cached");
      xlate(32'h0123_4300, 0, 0, "R6 hit after refill");

      repeat (4) @(negedge clk);
      n_vec++;
      if (sb.size() != 0) fail("R9", "missing responses", sb.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule